// File: doc/BRIEF.md
# Stereo PDM Microphone Decimator

This block drives the bit clock for a pair of external pulse-density-modulated digital microphones that share one data wire. It captures one bit per channel in each bit-clock period, one on the rising edge and one on the falling edge. It then converts each one-bit stream into signed 16-bit PCM samples. Every channel passes through a fourth-order integrator/comb decimator, a short high-frequency compensation stage and a saturating output.

The output rate is chosen at run time. With `rate_16k` low, one sample is produced per 300 bit periods. With it high, one sample is produced per 150 bit periods. At a 2.4 MHz bit clock these ratios give 8 kHz and 16 kHz. A swap control exchanges which clock edge feeds which channel. Changing the rate, or dropping `en`, clears the filter state. Output then stays quiet until the filter has refilled.

The sample output is a stream that carries a one-cycle valid strobe and has no ready input. A new sample pair arrives only every few hundred bit-clock periods, and the block keeps no copy of a sample once it is presented. The sink must therefore take `pcm_left` and `pcm_right` in the cycle `pcm_valid` is high. The sink cannot apply back-pressure.

Top module: `pdm_stereo_decim`

## Requirements
- R1: While `en` is high, `pdm_clk` is a square wave that is high for HALF_DIV system cycles and low for HALF_DIV system cycles.
- R2: With `edge_swap` = 0 the left channel takes `pdm_data` at the rising transition of `pdm_clk` and the right channel takes it at the falling transition. With `edge_swap` = 1 the assignment is reversed.
- R3: After settling, `pcm_valid` pulses once every 300 bit-clock periods when `rate_16k` = 0 and once every 150 bit-clock periods when `rate_16k` = 1.
- R4: A data bit of 1 counts as +1 and a bit of 0 counts as −1. Take a settled input whose pattern repeats with a period that divides the ratio R, and let S be the sum of the ±1 values over R bits. The output is then floor(R³·S / 2^K), where K = 18 for R = 300 and K = 14 for R = 150. All ones gives 30899 and all zeros gives −30900 in both modes. The decimator never overflows.
- R5: The compensation stage outputs floor((5·y[n] − y[n−1]) / 4) of the scaled decimator outputs y. It therefore has a DC gain of exactly 1.
- R6: Outputs are clipped to the range −32768 to 32767. On a full-scale step between all-zeros and all-ones, the transient reaches 32767 on the way up and −32768 on the way down.
- R7: `pcm_valid` is high for exactly one cycle per sample, and `pcm_left` and `pcm_right` are valid together in that cycle.
- R8: A change of `rate_16k`, or a rising edge of `en`, clears the filter. The first four decimation results after the clear are suppressed, so the first `pcm_valid` comes about 5·R bit periods later and carries the settled value.
- R9: While `en` is low, `pdm_clk` stays low and `pcm_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the bit clock and the filters; low clears them |
| rate_16k | input | 1 | 0: ratio 300, 1: ratio 150 |
| edge_swap | input | 1 | Exchanges the capture edges of the two channels |
| pdm_data | input | 1 | Shared one-bit microphone data line |
| pdm_clk | output | 1 | Bit clock to the microphones |
| pcm_valid | output | 1 | One-cycle strobe for a new sample pair |
| pcm_left | output | 16 | Signed left sample |
| pcm_right | output | 16 | Signed right sample |

## Verification
The bench feeds patterns that repeat with a period dividing 150. For such patterns the settled output does not depend on where the decimation boundary falls, so every settled sample has an exact expected value. A wrong bit-to-sign mapping, a missing integrator or comb stage, or a wrong scaling shift would all change that value. A design that mixed up the two capture edges, or ignored the swap control, would return the other channel's value. The bench also applies a full-scale step without clearing the filter. A design without clipping would wrap to a value of the opposite sign. Finally, the bench measures the time from a rate change or restart to the first strobe. A design that released early would present half-filled filter output, and one that forgot to clear would present a stale value.

// File: rtl/pdm_stereo_pkg.sv
package pdm_stereo_pkg;
  localparam int unsigned CIC_ORDER   = 4;
  localparam int unsigned SETTLE_DECS = 4;
  localparam int unsigned PCM_W       = 16;
  localparam int unsigned Y_W         = 18;
  typedef logic signed [PCM_W-1:0] pcm_t;
endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
  parameter int unsigned HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pdm_clk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          clk_q;
  logic          wrap;

  assign wrap      = en && (cnt == LAST);
  assign rise_tick = wrap && !clk_q;
  assign fall_tick = wrap && clk_q;
  assign pdm_clk   = clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r9_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pdm_clk);
  a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rise_tick && !fall_tick) |=> $stable(pdm_clk));
endmodule

// File: rtl/pdm_cic4.sv
module pdm_cic4 #(
  parameter int unsigned ORDER = 4,
  parameter int unsigned W     = 37,
  parameter int unsigned YW    = 18,
  parameter int unsigned SH_LO = 18,
  parameter int unsigned SH_HI = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 bit_en,
  input  logic                 bit_in,
  input  logic                 dec_en,
  input  logic                 use_hi,
  output logic signed [YW-1:0] y_out,
  output logic                 y_vld
);
  logic signed [W-1:0] integ [ORDER];
  logic signed [W-1:0] dly   [ORDER];
  logic signed [W-1:0] cs    [ORDER+1];
  logic signed [W-1:0] cic_q;
  logic signed [W-1:0] scaled;
  logic signed [W-1:0] step;

  assign step = {{(W-1){~bit_in}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ORDER; i++) integ[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < ORDER; i++) integ[i] <= '0;
    end else if (bit_en) begin
      integ[0] <= integ[0] + step;
      for (int i = 1; i < ORDER; i++) integ[i] <= integ[i] + integ[i-1];
    end
  end

  always_comb begin
    cs[0] = integ[ORDER-1];
    for (int i = 0; i < ORDER; i++) cs[i+1] = cs[i] - dly[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ORDER; i++) dly[i] <= '0;
      cic_q <= '0;
      y_vld <= 1'b0;
    end else if (clr) begin
      for (int i = 0; i < ORDER; i++) dly[i] <= '0;
      cic_q <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= dec_en;
      if (dec_en) begin
        for (int i = 0; i < ORDER; i++) dly[i] <= cs[i];
        cic_q <= cs[ORDER];
      end
    end
  end

  assign scaled = use_hi ? (cic_q >>> SH_HI) : (cic_q >>> SH_LO);
  assign y_out  = scaled[YW-1:0];

  a_r4_scaled_fits: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> (scaled[W-1:YW-1] == '0 || scaled[W-1:YW-1] == '1));
  a_r3_dec_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> bit_en);
endmodule

// File: rtl/pdm_comp_sat.sv
module pdm_comp_sat #(
  parameter int unsigned YW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic                 gate,
  input  logic signed [YW-1:0] y_in,
  output logic                 out_vld,
  output pdm_stereo_pkg::pcm_t out_pcm
);
  localparam int unsigned AW = YW + 3;
  localparam logic signed [AW-1:0] PMAX = AW'(32767);
  localparam logic signed [AW-1:0] NMIN = -AW'(32768);

  logic signed [YW-1:0] prev;
  logic signed [AW-1:0] ext_y, ext_p, acc, q;
  pdm_stereo_pkg::pcm_t clipped;

  assign ext_y = {{3{y_in[YW-1]}}, y_in};
  assign ext_p = {{3{prev[YW-1]}}, prev};
  assign acc   = (ext_y <<< 2) + ext_y - ext_p;
  assign q     = acc >>> 2;

  always_comb begin
    if (q > PMAX)      clipped = 16'sh7fff;
    else if (q < NMIN) clipped = 16'sh8000;
    else               clipped = q[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      out_vld <= 1'b0;
      out_pcm <= '0;
    end else if (clr) begin
      prev    <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld && gate;
      if (in_vld) begin
        prev    <= y_in;
        out_pcm <= clipped;
      end
    end
  end

  a_r6_clip_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && in_vld && q > PMAX) |=> out_pcm == 16'sh7fff);
  a_r6_clip_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && in_vld && q < NMIN) |=> out_pcm == 16'sh8000);
endmodule

// File: rtl/pdm_stereo_decim.sv
module pdm_stereo_decim #(
  parameter int unsigned HALF_DIV  = 20,
  parameter int unsigned RATIO_LO  = 300,
  parameter int unsigned RATIO_HI  = 150,
  parameter int unsigned SHIFT_LO  = 18,
  parameter int unsigned SHIFT_HI  = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        rate_16k,
  input  logic        edge_swap,
  input  logic        pdm_data,
  output logic        pdm_clk,
  output logic        pcm_valid,
  output logic [15:0] pcm_left,
  output logic [15:0] pcm_right
);
  import pdm_stereo_pkg::*;

  localparam int unsigned DCW  = $clog2(RATIO_LO);
  localparam int unsigned ACCW = 1 + CIC_ORDER * DCW;
  localparam int unsigned SCW  = $clog2(SETTLE_DECS + 1);
  localparam int unsigned NCH  = 2;

  logic           mode_q, flush;
  logic           rise_tick, fall_tick, tick_d;
  logic           bit_rise, bit_fall;
  logic [NCH-1:0] ch_bit;
  logic [DCW-1:0] dec_cnt, ratio_last;
  logic           dec;
  logic [SCW-1:0] settle_cnt;
  logic           gate;
  logic [NCH-1:0] y_vld, o_vld;
  logic signed [Y_W-1:0] y_ch [NCH];
  pcm_t           o_pcm [NCH];

  pdm_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en),
    .pdm_clk(pdm_clk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  assign flush      = !en || (rate_16k != mode_q);
  assign ratio_last = rate_16k ? DCW'(RATIO_HI - 1) : DCW'(RATIO_LO - 1);
  assign dec        = tick_d && (dec_cnt == ratio_last);
  assign ch_bit     = edge_swap ? {bit_rise, bit_fall} : {bit_fall, bit_rise};
  assign gate       = (settle_cnt == SCW'(SETTLE_DECS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      tick_d     <= 1'b0;
      bit_rise   <= 1'b0;
      bit_fall   <= 1'b0;
      dec_cnt    <= '0;
      settle_cnt <= '0;
    end else begin
      mode_q <= rate_16k;
      tick_d <= rise_tick;
      if (rise_tick) bit_rise <= pdm_data;
      if (fall_tick) bit_fall <= pdm_data;
      if (flush) begin
        dec_cnt    <= '0;
        settle_cnt <= '0;
      end else begin
        if (tick_d) dec_cnt <= dec ? '0 : dec_cnt + 1'b1;
        if (y_vld[0] && !gate) settle_cnt <= settle_cnt + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pdm_cic4 #(
      .ORDER(CIC_ORDER), .W(ACCW), .YW(Y_W),
      .SH_LO(SHIFT_LO), .SH_HI(SHIFT_HI)
    ) u_cic (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .bit_en(tick_d), .bit_in(ch_bit[c]), .dec_en(dec),
      .use_hi(rate_16k), .y_out(y_ch[c]), .y_vld(y_vld[c])
    );
    pdm_comp_sat #(.YW(Y_W)) u_comp (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .in_vld(y_vld[c]), .gate(gate), .y_in(y_ch[c]),
      .out_vld(o_vld[c]), .out_pcm(o_pcm[c])
    );
  end

  assign pcm_valid = &o_vld;
  assign pcm_left  = o_pcm[0];
  assign pcm_right = o_pcm[1];

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);
  a_r8_quiet_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pcm_valid);
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> dec_cnt <= ratio_last);
  a_r7_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld[0] == o_vld[1]);
endmodule

// File: tb/pdm_stereo_decim_tb.sv
module pdm_stereo_decim_tb;
  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        rate_16k = 1'b0;
  logic        edge_swap = 1'b0;
  logic        pdm_data = 1'b0;
  logic        pdm_clk;
  logic        pcm_valid;
  logic [15:0] pcm_left, pcm_right;

  int nvec = 0, nerr = 0, cyc = 0;
  bit [149:0] pat_l, pat_r;
  int per_l = 1, per_r = 1;
  int idx_l = 0, idx_r = 0;
  logic prev_pclk = 1'b0;

  pdm_stereo_decim #(.HALF_DIV(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_16k(rate_16k),
    .edge_swap(edge_swap), .pdm_data(pdm_data), .pdm_clk(pdm_clk),
    .pcm_valid(pcm_valid), .pcm_left(pcm_left), .pcm_right(pcm_right)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // microphone model: left bit while clock low, right bit while clock high
  always @(negedge clk) begin
    if (pdm_clk != prev_pclk) begin
      if (!pdm_clk) begin
        pdm_data <= pat_l[idx_l % per_l];
        idx_l <= idx_l + 1;
      end else begin
        pdm_data <= pat_r[idx_r % per_r];
        idx_r <= idx_r + 1;
      end
    end
    prev_pclk <= pdm_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expv(input bit [149:0] p, input int per, input bit hi);
    int r = hi ? 150 : 300;
    int k = hi ? 14 : 18;
    int ones = 0;
    longint v;
    for (int i = 0; i < per; i++) ones += p[i];
    v = longint'(r) * r * r * ((r / per) * (2 * ones - per));
    return int'(v >>> k);
  endfunction

  task automatic wait_valid(output int l, output int r, output int t);
    do @(negedge clk); while (!pcm_valid);
    l = int'($signed(pcm_left));
    r = int'($signed(pcm_right));
    t = cyc;
  endtask

  task automatic restart(output int t0);
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1; t0 = cyc;
  endtask

  task automatic set_const(input bit l, input bit r);
    pat_l = {150{l}}; pat_r = {150{r}}; per_l = 1; per_r = 1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int l, r, t, t0, t1, hi, lo, mx, mn, win;
    int per_list [12] = '{1, 2, 3, 5, 6, 10, 15, 25, 30, 50, 75, 150};
    void'($urandom(32'd4242));
    set_const(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9 reset pdm_clk", int'(pdm_clk), 0);
    chk("R9 reset pcm_valid", int'(pcm_valid), 0);
    rst_n = 1'b1;

    // R1: bit clock shape
    restart(t0);
    for (int n = 0; n < 3; n++) begin
      while (pdm_clk) @(negedge clk);
      while (!pdm_clk) @(negedge clk);
      hi = 0; while (pdm_clk) begin hi++; @(negedge clk); end
      lo = 0; while (!pdm_clk) begin lo++; @(negedge clk); end
      chk("R1 high time", hi, HD);
      chk("R1 low time", lo, HD);
    end

    // R4/R8: constant streams, 8 kHz mode, release timing
    restart(t0);
    wait_valid(l, r, t);
    chk("R4 ones lo-rate", l, 30899);
    chk("R4 zeros lo-rate", r, -30900);
    win = t - t0 - 5 * 300 * 2 * HD;
    chk("R8 release window lo-rate", int'(win > -12 && win < 12), 1);
    @(negedge clk);
    chk("R7 strobe width", int'(pcm_valid), 0);
    wait_valid(l, r, t1);
    chk("R3 interval lo-rate", t1 - t, 300 * 2 * HD);
    chk("R5 steady gain", l, 30899);

    // R8: rate change clears and refills
    @(negedge clk); rate_16k = 1'b1; t0 = cyc;
    wait_valid(l, r, t);
    win = t - t0 - 5 * 150 * 2 * HD;
    chk("R8 release window hi-rate", int'(win > -12 && win < 12), 1);
    chk("R4 ones hi-rate", l, 30899);
    chk("R4 zeros hi-rate", r, -30900);
    wait_valid(l, r, t1);
    chk("R3 interval hi-rate", t1 - t, 150 * 2 * HD);

    // R2: swapped edges
    edge_swap = 1'b1;
    restart(t0);
    wait_valid(l, r, t);
    chk("R2 swap left", l, -30900);
    chk("R2 swap right", r, 30899);
    edge_swap = 1'b0;

    // R6: full-scale steps without clearing
    set_const(1'b0, 1'b0);
    restart(t0);
    for (int n = 0; n < 2; n++) wait_valid(l, r, t);
    set_const(1'b1, 1'b1);
    mx = -100000;
    for (int n = 0; n < 7; n++) begin
      wait_valid(l, r, t);
      if (l > mx) mx = l;
    end
    chk("R6 clip high", mx, 32767);
    chk("R5 settle after rise", l, 30899);
    set_const(1'b0, 1'b0);
    mn = 100000;
    for (int n = 0; n < 7; n++) begin
      wait_valid(l, r, t);
      if (r < mn) mn = r;
    end
    chk("R6 clip low", mn, -32768);
    chk("R5 settle after fall", r, -30900);

    // R4/R2/R5: random periodic patterns
    for (int v = 0; v < 6; v++) begin
      per_l = per_list[$urandom % 12];
      per_r = per_list[$urandom % 12];
      for (int i = 0; i < 150; i++) begin
        pat_l[i] = 1'($urandom);
        pat_r[i] = 1'($urandom);
      end
      rate_16k = 1'($urandom);
      edge_swap = 1'($urandom);
      restart(t0);
      for (int n = 0; n < 2; n++) begin
        wait_valid(l, r, t);
        if (edge_swap) begin
          chk("R2 R4 random left", l, expv(pat_r, per_r, rate_16k));
          chk("R2 R4 random right", r, expv(pat_l, per_l, rate_16k));
        end else begin
          chk("R4 R5 random left", l, expv(pat_l, per_l, rate_16k));
          chk("R4 R5 random right", r, expv(pat_r, per_r, rate_16k));
        end
      end
    end

    // R9: disabled
    @(negedge clk); en = 1'b0;
    hi = 0; lo = 0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (n > 0 && pdm_clk) hi++;
      if (pcm_valid) lo++;
    end
    chk("R9 clock idle", hi, 0);
    chk("R9 no strobe", lo, 0);

    finish_run();
  end
endmodule